// File: doc/BRIEF.md
# Memory Channel Initialization Sequencer

This block is a controller-side state machine that prepares a chain of up to 32 serially configured memory devices for use. After a start pulse it walks through a fixed, ordered list of control operations and offers them one at a time to a serial transport. Each operation is either a register write, a serial-reset, a set-reset or a clear-reset command. The transport shifts the bits out and acknowledges each request.

The order cannot be changed. First come three broadcast operations: a serial reset, a zeroing write to a guard register, and a write of the channel clock period in 64 ps units. Next, every device gets a chain position ID and then a memory ID. The power-exit, read-latency and row-to-column timing registers follow. Last, each device receives a set-reset and then a clear-reset. When the last clear-reset has been accepted, the block raises `done` and holds it until the next start.

Top module: `mem_chain_init_seq`

## Requirements
- R1: After reset, `req_valid` and `done` are 0 until a start is accepted.
- R2: A `start` seen while idle or done begins the sequence with a broadcast serial reset: `req_op`=1, `req_bcast`=1, `req_addr`=0, `req_reg`=0, `req_data`=0.
- R3: The request after the serial reset is a broadcast write (`req_op`=0) of data 0 to guard register 0x0E0, address 0.
- R4: The third request is a broadcast write to period register 0x0E1, address 0, with data `per_ps` divided by 64 (truncated).
- R5: For devices i = 0 .. N-1, nearest first, a write to chain ID register 0x010 is sent to the unassigned default address 31 with data i, broadcast flag 0.
- R6: For devices i = 0 .. N-1, a write to memory ID register 0x011 at address i carries `devid_map[5i+4:5i]`, zero-extended.
- R7: The timing registers are written next, one register after another. Within each register the devices go in order 0 .. N-1 at address i. The registers are power-exit A (0x020, `pwr_exit_a`), power-exit B (0x021, `pwr_exit_b`), nap-exit (0x022, `nap_exit`), read latency A (0x030, `rdlat_a`), read latency B (0x031, `rdlat_b`) and row-to-column (0x032, `row_col`), in that order.
- R8: Each device i in order 0 .. N-1 then receives a set-reset (`req_op`=2) and directly after it a clear-reset (`req_op`=3), both at address i with register and data 0.
- R9: An offered request keeps every field unchanged until `req_ready` is seen with it. The sequence advances only on such an acceptance.
- R10: After the last clear-reset is accepted, `done` goes to 1 in the next cycle with `req_valid` 0 and stays there. A new start restarts from R2.
- R11: With a device count of 0, `done` follows acceptance of the period write with no per-device requests.
- R12: A `dev_count` above 32 is treated as 32.
- R13: A `start` pulse while a sequence is running is ignored. The request stream continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin the sequence (taken while idle or done) |
| dev_count | input | 6 | Number of devices on the chain, captured at start |
| per_ps | input | 22 | Channel clock period in picoseconds |
| devid_map | input | 160 | Memory ID for device i in bits 5i+4:5i |
| pwr_exit_a | input | 16 | Value for power-exit register A |
| pwr_exit_b | input | 16 | Value for power-exit register B |
| nap_exit | input | 16 | Value for nap-exit register |
| rdlat_a | input | 16 | Minimum read latency value A |
| rdlat_b | input | 16 | Minimum read latency value B |
| row_col | input | 16 | Row-to-column delay value |
| req_ready | input | 1 | Transport accepts the current request |
| req_valid | output | 1 | A request is offered |
| req_op | output | 2 | 0 write, 1 serial reset, 2 set-reset, 3 clear-reset |
| req_bcast | output | 1 | Request goes to all devices |
| req_addr | output | 5 | Serial device address |
| req_reg | output | 12 | Register address |
| req_data | output | 16 | Write data |
| done | output | 1 | Sequence complete |

## Verification
The properties assume that `req_ready` is the only handshake input and that `dev_count`, `per_ps`, the ID map and the timing values stay constant from a start until `done`. The stream-order checks depend on that. The bench sets all configuration inputs before it pulses start and leaves them alone until `done`. Only `req_ready`, toggled pseudo-randomly each cycle, and one deliberate mid-run start pulse change during a run. The stall property also assumes the transport never withdraws readiness in a way that matters to the block. Any pattern is legal, because the block only looks at ready together with valid.

// File: rtl/mem_chain_init_seq.sv
module mem_chain_init_seq #(
  parameter int ADDR_W = 5,
  parameter int REG_W = 12,
  parameter int DATA_W = 16,
  parameter int MAX_DEV = 32,
  parameter int PS_W = 22,
  parameter int PS_SHIFT = 6,
  parameter logic [ADDR_W-1:0] DFLT_ADDR = 5'd31,
  parameter logic [REG_W-1:0] REG_GUARD = 12'h0E0,
  parameter logic [REG_W-1:0] REG_PERIOD = 12'h0E1,
  parameter logic [REG_W-1:0] REG_CHAIN_ID = 12'h010,
  parameter logic [REG_W-1:0] REG_MEM_ID = 12'h011,
  parameter logic [REG_W-1:0] REG_PX_A = 12'h020,
  parameter logic [REG_W-1:0] REG_PX_B = 12'h021,
  parameter logic [REG_W-1:0] REG_NAPX = 12'h022,
  parameter logic [REG_W-1:0] REG_RLAT_A = 12'h030,
  parameter logic [REG_W-1:0] REG_RLAT_B = 12'h031,
  parameter logic [REG_W-1:0] REG_ROWCOL = 12'h032,
  localparam int CNT_W = $clog2(MAX_DEV + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [CNT_W-1:0]          dev_count,
  input  logic [PS_W-1:0]           per_ps,
  input  logic [MAX_DEV*ADDR_W-1:0] devid_map,
  input  logic [DATA_W-1:0]         pwr_exit_a,
  input  logic [DATA_W-1:0]         pwr_exit_b,
  input  logic [DATA_W-1:0]         nap_exit,
  input  logic [DATA_W-1:0]         rdlat_a,
  input  logic [DATA_W-1:0]         rdlat_b,
  input  logic [DATA_W-1:0]         row_col,
  input  logic                      req_ready,
  output logic                      req_valid,
  output logic [1:0]                req_op,
  output logic                      req_bcast,
  output logic [ADDR_W-1:0]         req_addr,
  output logic [REG_W-1:0]          req_reg,
  output logic [DATA_W-1:0]         req_data,
  output logic                      done
);

  typedef enum logic [3:0] {
    S_IDLE, S_SRST, S_GUARD, S_PERIOD, S_CHAIN, S_MEMID,
    S_PXA, S_PXB, S_NAPX, S_RLA, S_RLB, S_ROWCOL,
    S_SET, S_CLR, S_DONE
  } st_t;

  st_t st, nst;
  logic [ADDR_W-1:0] dev, ndev;
  logic [CNT_W-1:0] n_dev;

  wire idle_like = (st == S_IDLE) || (st == S_DONE);
  wire take = req_valid && req_ready;
  wire dev_last = (CNT_W'(dev) + CNT_W'(1)) == n_dev;
  wire [CNT_W-1:0] n_clamped = (dev_count > CNT_W'(MAX_DEV)) ? CNT_W'(MAX_DEV) : dev_count;

  always_comb begin
    nst = st;
    ndev = dev;
    case (st)
      S_IDLE, S_DONE: if (start) begin nst = S_SRST; ndev = '0; end
      S_SRST:   if (take) nst = S_GUARD;
      S_GUARD:  if (take) nst = S_PERIOD;
      S_PERIOD: if (take) nst = (n_dev == '0) ? S_DONE : S_CHAIN;
      S_SET:    if (take) nst = S_CLR;
      S_CLR: if (take) begin
        if (dev_last) nst = S_DONE;
        else begin nst = S_SET; ndev = dev + 1'b1; end
      end
      default: if (take) begin
        if (dev_last) begin nst = st_t'(st + 4'd1); ndev = '0; end
        else ndev = dev + 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      dev <= '0;
      n_dev <= '0;
    end else begin
      st <= nst;
      dev <= ndev;
      if (idle_like && start) n_dev <= n_clamped;
    end
  end

  assign req_valid = !idle_like;
  assign done = (st == S_DONE);
  assign req_bcast = (st == S_SRST) || (st == S_GUARD) || (st == S_PERIOD);
  assign req_op = (st == S_SRST) ? 2'd1 :
                  (st == S_SET)  ? 2'd2 :
                  (st == S_CLR)  ? 2'd3 : 2'd0;
  assign req_addr = req_bcast ? '0 : (st == S_CHAIN) ? DFLT_ADDR : dev;

  always_comb begin
    case (st)
      S_GUARD:  req_reg = REG_GUARD;
      S_PERIOD: req_reg = REG_PERIOD;
      S_CHAIN:  req_reg = REG_CHAIN_ID;
      S_MEMID:  req_reg = REG_MEM_ID;
      S_PXA:    req_reg = REG_PX_A;
      S_PXB:    req_reg = REG_PX_B;
      S_NAPX:   req_reg = REG_NAPX;
      S_RLA:    req_reg = REG_RLAT_A;
      S_RLB:    req_reg = REG_RLAT_B;
      S_ROWCOL: req_reg = REG_ROWCOL;
      default:  req_reg = '0;
    endcase
  end

  always_comb begin
    case (st)
      S_PERIOD: req_data = DATA_W'(per_ps >> PS_SHIFT);
      S_CHAIN:  req_data = DATA_W'(dev);
      S_MEMID:  req_data = DATA_W'(devid_map[dev*ADDR_W +: ADDR_W]);
      S_PXA:    req_data = pwr_exit_a;
      S_PXB:    req_data = pwr_exit_b;
      S_NAPX:   req_data = nap_exit;
      S_RLA:    req_data = rdlat_a;
      S_RLB:    req_data = rdlat_b;
      S_ROWCOL: req_data = row_col;
      default:  req_data = '0;
    endcase
  end

endmodule

// File: rtl/mem_chain_init_chk.sv
module mem_chain_init_chk #(
  parameter int ADDR_W = 5,
  parameter int REG_W = 12,
  parameter int DATA_W = 16,
  parameter logic [REG_W-1:0] REG_GUARD = 12'h0E0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_op,
  input logic              req_bcast,
  input logic [ADDR_W-1:0] req_addr,
  input logic [REG_W-1:0]  req_reg,
  input logic [DATA_W-1:0] req_data,
  input logic              done
);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_op) && $stable(req_bcast)
      && $stable(req_addr) && $stable(req_reg) && $stable(req_data));

  assert_first_srst_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid && start |=> req_valid && req_op == 2'd1 && req_bcast);

  assert_guard_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_op == 2'd1 |=>
      req_valid && req_op == 2'd0 && req_bcast && req_reg == REG_GUARD && req_data == '0);

  assert_clr_after_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_op == 2'd2 |=>
      req_valid && req_op == 2'd3 && req_addr == $past(req_addr));

  assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_valid);

  assert_done_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);

endmodule

bind mem_chain_init_seq mem_chain_init_chk #(
  .ADDR_W(ADDR_W), .REG_W(REG_W), .DATA_W(DATA_W), .REG_GUARD(REG_GUARD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .req_valid(req_valid),
  .req_ready(req_ready), .req_op(req_op), .req_bcast(req_bcast),
  .req_addr(req_addr), .req_reg(req_reg), .req_data(req_data), .done(done)
);

// File: tb/tb_mem_chain_init_seq.sv
`timescale 1ns/1ps
module tb_mem_chain_init_seq;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [5:0] dev_count = '0;
  logic [21:0] per_ps = '0;
  logic [159:0] devid_map = '0;
  logic [15:0] pwr_exit_a = 16'h0011, pwr_exit_b = 16'h0022, nap_exit = 16'h0033;
  logic [15:0] rdlat_a = 16'h0044, rdlat_b = 16'h0055, row_col = 16'h0066;
  logic req_ready = 1'b0;
  logic req_valid, req_bcast, done;
  logic [1:0] req_op;
  logic [4:0] req_addr;
  logic [11:0] req_reg;
  logic [15:0] req_data;

  int total = 0;
  int bad = 0;
  logic [35:0] q[$];

  always #5 clk = ~clk;

  mem_chain_init_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dev_count(dev_count), .per_ps(per_ps),
    .devid_map(devid_map), .pwr_exit_a(pwr_exit_a), .pwr_exit_b(pwr_exit_b),
    .nap_exit(nap_exit), .rdlat_a(rdlat_a), .rdlat_b(rdlat_b), .row_col(row_col),
    .req_ready(req_ready), .req_valid(req_valid), .req_op(req_op), .req_bcast(req_bcast),
    .req_addr(req_addr), .req_reg(req_reg), .req_data(req_data), .done(done)
  );

  function automatic logic [35:0] mk(input int op, input int b, input int a, input int r, input int d);
    return {op[1:0], b[0], a[4:0], r[11:0], d[15:0]};
  endfunction

  function automatic string tag_of(input logic [35:0] e);
    logic [1:0] op = e[35:34];
    logic [11:0] r = e[27:16];
    if (op == 2'd1) return "R2";
    if (op != 2'd0) return "R8";
    if (r == 12'h0E0) return "R3";
    if (r == 12'h0E1) return "R4";
    if (r == 12'h010) return "R5";
    if (r == 12'h011) return "R6";
    return "R7";
  endfunction

  task automatic check(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_seq(input int n, input int ps, input int mul, input int add,
                         input int rdy_pct, input bit poke, input string end_tag);
    int nd = (n > 32) ? 32 : n;
    int half;
    bit poked = 0;
    logic [15:0] tv[6] = '{pwr_exit_a, pwr_exit_b, nap_exit, rdlat_a, rdlat_b, row_col};
    int tr[6] = '{'h020, 'h021, 'h022, 'h030, 'h031, 'h032};
    dev_count = n[5:0];
    per_ps = ps[21:0];
    for (int i = 0; i < 32; i++) devid_map[i*5 +: 5] = 5'((i * mul + add) % 32);
    q.delete();
    q.push_back(mk(1, 1, 0, 0, 0));
    q.push_back(mk(0, 1, 0, 'h0E0, 0));
    q.push_back(mk(0, 1, 0, 'h0E1, ps / 64));
    for (int i = 0; i < nd; i++) q.push_back(mk(0, 0, 31, 'h010, i));
    for (int i = 0; i < nd; i++) q.push_back(mk(0, 0, i, 'h011, (i * mul + add) % 32));
    for (int k = 0; k < 6; k++)
      for (int i = 0; i < nd; i++) q.push_back(mk(0, 0, i, tr[k], int'(tv[k])));
    for (int i = 0; i < nd; i++) begin
      q.push_back(mk(2, 0, i, 0, 0));
      q.push_back(mk(3, 0, i, 0, 0));
    end
    half = q.size() / 2;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (q.size() > 0) begin
      logic [35:0] act = {req_op, req_bcast, req_addr, req_reg, req_data};
      bit rdy;
      start = 1'b0;
      check(req_valid && !done && act == q[0], tag_of(q[0]), {act[35:1], req_valid}, q[0]);
      rdy = ($urandom_range(99) < rdy_pct);
      req_ready = rdy;
      if (poke && !poked && q.size() == half) begin
        start = 1'b1;
        poked = 1;
        check(1'b1, "R13", '0, '0);
      end
      if (req_valid && rdy) void'(q.pop_front());
      @(negedge clk);
    end
    start = 1'b0;
    req_ready = 1'b0;
    for (int c = 0; c < 3; c++) begin
      check(done && !req_valid, end_tag, {34'd0, done, req_valid}, 36'd2);
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!req_valid && !done, "R1", {34'd0, req_valid, done}, 36'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!req_valid && !done, "R1", {34'd0, req_valid, done}, 36'd0);
    // R2..R9, R13: three devices, stalling transport, mid-run start ignored
    run_seq(3, 2500, 7, 3, 60, 1'b1, "R10");
    // R11: empty chain
    run_seq(0, 1875, 5, 1, 70, 1'b0, "R11");
    // R10: restart from done, single device, transport always ready
    run_seq(1, 640, 5, 9, 100, 1'b0, "R10");
    // R12: count above maximum clamps to 32
    run_seq(40, 3003, 9, 4, 80, 1'b0, "R12");
    run_seq(32, 2000, 3, 0, 50, 1'b0, "R10");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule